// File: doc/BRIEF.md
# DMA Bus Hold Arbiter

This block lets a DMA controller take the system bus from an 8-bit CPU that has no native bus-grant input. It watches the CPU's status lines, its lock line and a decoded T-state code. It answers the controller's hold request with a hold acknowledge only at a safe point: when the status shows a passive bus, or in the last T-state of a running bus cycle. A locked instruction sequence blocks the grant for as long as the lock line is low.

When the grant is given, three things change on the same clock edge. The CPU-side bus paths for address, data and command are cut from the system bus. The ready enable to the clock generator is removed, so the CPU is kept not-ready. A wait latch is set. When the controller drops its request, the hand-back runs in a fixed order. The hold acknowledge falls first. After a programmable dead gap the CPU paths reconnect. Ready is enabled again one cycle later, and the wait latch clears one cycle after that. A one-cycle restart strobe marks the point where the stalled CPU cycle may show on the system bus as a fresh T1.

Top module: `hold_arb`

## Requirements
- R1: During and after synchronous reset (`rst` high), `hlda` is 0, every bit of `cpu_path_en` is 1, `rdy_en` is 1, `wait_hold` is 0 and `cyc_restart` is 0.
- R2: With the block idle, `hreq` high, `cpu_lock_n` high and `cpu_st` equal to 3'b111 (passive), `hlda` is 1 after the next clock edge, whatever the `tstate` code is.
- R3: The T-state codes are 0 idle, 1 T1, 2 T2, 3 T3, 4 T4 and 5 wait. With a non-passive status, a grant happens only when `tstate` is 4 at the sampling edge. Codes 1, 2, 3 and 5 never produce a grant.
- R4: On the edge that raises `hlda`, every `cpu_path_en` bit goes to 0, `rdy_en` goes to 0 and `wait_hold` goes to 1.
- R5: While `cpu_lock_n` is low, no grant is made, even at T4 or with passive status, and even across several locked bus cycles.
- R6: While `hreq` stays high, `hlda` stays high whatever the CPU inputs do. `hlda` falls on the first edge that samples `hreq` low.
- R7: `cpu_path_en` is never 1 while `hlda` is 1. The path enables return to 1 exactly RELEASE_GAP cycles (default 1) after `hlda` falls.
- R8: `rdy_en` returns to 1 one cycle after the CPU paths reconnect. `wait_hold` returns to 0 one cycle after `rdy_en` returns.
- R9: `cyc_restart` is 1 for exactly one cycle: the first cycle in which `wait_hold` is back at 0 after a hand-back.
- R10: A request that is raised again during the hand-back is not granted before `wait_hold` has cleared. With a passive status, it is granted on the edge right after the cycle that shows `cyc_restart`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hreq | input | 1 | Hold request from the DMA controller, already qualified |
| cpu_st | input | ST_W (3) | CPU status lines; all ones means passive |
| cpu_lock_n | input | 1 | CPU lock line, active low |
| tstate | input | 3 | Decoded T-state code of the current CPU clock |
| hlda | output | 1 | Hold acknowledge to the DMA controller |
| cpu_path_en | output | N_PATHS (3) | CPU-side bus connect enables: bit 0 address, bit 1 data, bit 2 command |
| rdy_en | output | 1 | Ready enable to the clock generator; 0 keeps the CPU not-ready |
| wait_hold | output | 1 | Wait latch state |
| cyc_restart | output | 1 | One-cycle strobe: the stalled CPU cycle restarts at T1 |

## Verification
The bench goes after grants that land in the middle of a bus cycle (T1, T2, T3 or wait with an active status). A design that decoded the safe point too loosely would raise `hlda` while the CPU still drives the bus. It holds a request across two locked bus cycles that each reach T4. A design that ignored the lock line there would break an atomic read-modify-write. It also walks the hand-back cycle by cycle and re-raises the request during it. A wrong order would either let both sides drive the bus at once or release the CPU before its paths are connected. A random phase with random wait states and request timing checks, on every edge, the grant point and that the two sides never overlap.

// File: rtl/hold_arb_pkg.sv
package hold_arb_pkg;

   // Arbiter sequence states
   typedef enum logic [2:0] {
      ARB_IDLE = 3'd0,   // CPU owns the bus
      ARB_OWN  = 3'd1,   // DMA owns the bus
      ARB_GAP  = 3'd2,   // acknowledge dropped, both sides off the bus
      ARB_BACK = 3'd3,   // CPU paths reconnected, still not ready
      ARB_RDY  = 3'd4    // ready restored, wait latch still set
   } arb_state_t;

   // T-state code width and values
   localparam int TS_W = 3;
   localparam logic [TS_W-1:0] TS_IDLE = 3'd0;
   localparam logic [TS_W-1:0] TS_T1   = 3'd1;
   localparam logic [TS_W-1:0] TS_T2   = 3'd2;
   localparam logic [TS_W-1:0] TS_T3   = 3'd3;
   localparam logic [TS_W-1:0] TS_T4   = 3'd4;
   localparam logic [TS_W-1:0] TS_TW   = 3'd5;

endpackage

// File: rtl/hold_arb_safe.sv
// Safe-point decode with an optional request synchronizer.
module hold_arb_safe
   import hold_arb_pkg::*;
#(
   parameter int ST_W        = 3,
   parameter int SYNC_STAGES = 0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              hreq,
   input  logic [ST_W-1:0]   cpu_st,
   input  logic              cpu_lock_n,
   input  logic [TS_W-1:0]   tstate,
   output logic              hreq_q,
   output logic              safe_pt
);

   localparam logic [ST_W-1:0] ST_PASSIVE = {ST_W{1'b1}};

   if (ST_W < 1) begin : g_bad_st
      $error("hold_arb_safe: ST_W must be at least 1");
   end
   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("hold_arb_safe: SYNC_STAGES must be 0 to 4");
   end

   logic st_passive;
   logic at_last_t;

   assign st_passive = (cpu_st == ST_PASSIVE);
   assign at_last_t  = (tstate == TS_T4);
   // the lock line vetoes every grant, passive or not
   assign safe_pt    = cpu_lock_n & (st_passive | at_last_t);

   if (SYNC_STAGES == 0) begin : g_direct
      logic unused_sync;
      assign unused_sync = &{1'b0, clk, rst};
      assign hreq_q = hreq;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] sync_r;
      always_ff @(posedge clk) begin
         if (rst) sync_r <= '0;
         else     sync_r <= {sync_r[SYNC_STAGES-1:0] , hreq} >> 0;
      end
      assign hreq_q = sync_r[SYNC_STAGES-1];
   end

endmodule

// File: rtl/hold_arb_seq.sv
// Grant / hand-back sequencer.
module hold_arb_seq
   import hold_arb_pkg::*;
#(
   parameter int RELEASE_GAP = 1
) (
   input  logic clk,
   input  logic rst,
   input  logic hreq,
   input  logic safe_pt,
   output logic hlda,
   output logic cpu_side,
   output logic rdy_en,
   output logic wait_hold,
   output logic cyc_restart
);

   localparam int GW = (RELEASE_GAP < 2) ? 1 : $clog2(RELEASE_GAP);
   localparam logic [GW-1:0] GAP_LOAD = GW'(RELEASE_GAP - 1);

   if (RELEASE_GAP < 1) begin : g_bad_gap
      $error("hold_arb_seq: RELEASE_GAP must be at least 1");
   end

   arb_state_t state_r, state_n;
   logic [GW-1:0] gap_r, gap_n;
   logic restart_r;

   always_comb begin
      state_n = state_r;
      gap_n   = gap_r;
      unique case (state_r)
         ARB_IDLE: if (hreq && safe_pt) state_n = ARB_OWN;
         ARB_OWN: begin
            if (!hreq) begin
               state_n = ARB_GAP;
               gap_n   = GAP_LOAD;
            end
         end
         ARB_GAP: begin
            if (gap_r == '0) state_n = ARB_BACK;
            else             gap_n   = gap_r - 1'b1;
         end
         ARB_BACK: state_n = ARB_RDY;
         ARB_RDY:  state_n = ARB_IDLE;
         default:  state_n = ARB_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_r   <= ARB_IDLE;
         gap_r     <= '0;
         restart_r <= 1'b0;
      end else begin
         state_r   <= state_n;
         gap_r     <= gap_n;
         restart_r <= (state_r == ARB_RDY);
      end
   end

   assign hlda        = (state_r == ARB_OWN);
   assign cpu_side    = (state_r == ARB_IDLE) || (state_r == ARB_BACK) ||
                        (state_r == ARB_RDY);
   assign rdy_en      = (state_r == ARB_IDLE) || (state_r == ARB_RDY);
   assign wait_hold   = (state_r != ARB_IDLE);
   assign cyc_restart = restart_r;

   AST_HLDA_FALLS: assert property (@(posedge clk) disable iff (rst)
      (hlda && !hreq) |=> !hlda);                                   // R6
   AST_HLDA_KEEPS: assert property (@(posedge clk) disable iff (rst)
      (hlda && hreq) |=> hlda);                                     // R6
   AST_READY_AFTER_BUS: assert property (@(posedge clk) disable iff (rst)
      $rose(rdy_en) |-> $past(cpu_side));                           // R8
   AST_WAIT_AFTER_READY: assert property (@(posedge clk) disable iff (rst)
      $fell(wait_hold) |-> $past(rdy_en));                          // R8
   AST_RESTART_PULSE: assert property (@(posedge clk) disable iff (rst)
      cyc_restart |=> !cyc_restart);                                // R9

endmodule

// File: rtl/hold_arb_iso.sv
// Per-path CPU bus isolation enables.
module hold_arb_iso #(
   parameter int N_PATHS = 3
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               cpu_side,
   input  logic               hlda,
   output logic [N_PATHS-1:0] path_en
);

   if (N_PATHS < 1 || N_PATHS > 16) begin : g_bad_paths
      $error("hold_arb_iso: N_PATHS must be 1 to 16");
   end

   for (genvar i = 0; i < N_PATHS; i++) begin : g_path
      // a path may connect only while the acknowledge is low
      assign path_en[i] = cpu_side & ~hlda;
   end

   AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
      hlda |-> (path_en == '0));                                    // R7
   AST_RECONNECT_AFTER_DROP: assert property (@(posedge clk) disable iff (rst)
      $rose(path_en[0]) |-> $past(!hlda));                          // R7

endmodule

// File: rtl/hold_arb.sv
module hold_arb
   import hold_arb_pkg::*;
#(
   parameter int ST_W        = 3,
   parameter int N_PATHS     = 3,
   parameter int RELEASE_GAP = 1,
   parameter int SYNC_STAGES = 0
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               hreq,
   input  logic [ST_W-1:0]    cpu_st,
   input  logic               cpu_lock_n,
   input  logic [2:0]         tstate,
   output logic               hlda,
   output logic [N_PATHS-1:0] cpu_path_en,
   output logic               rdy_en,
   output logic               wait_hold,
   output logic               cyc_restart
);

   logic hreq_q;
   logic safe_pt;
   logic cpu_side;

   hold_arb_safe #(.ST_W(ST_W), .SYNC_STAGES(SYNC_STAGES)) i_safe (
      .clk        (clk),
      .rst        (rst),
      .hreq       (hreq),
      .cpu_st     (cpu_st),
      .cpu_lock_n (cpu_lock_n),
      .tstate     (tstate),
      .hreq_q     (hreq_q),
      .safe_pt    (safe_pt)
   );

   hold_arb_seq #(.RELEASE_GAP(RELEASE_GAP)) i_seq (
      .clk         (clk),
      .rst         (rst),
      .hreq        (hreq_q),
      .safe_pt     (safe_pt),
      .hlda        (hlda),
      .cpu_side    (cpu_side),
      .rdy_en      (rdy_en),
      .wait_hold   (wait_hold),
      .cyc_restart (cyc_restart)
   );

   hold_arb_iso #(.N_PATHS(N_PATHS)) i_iso (
      .clk      (clk),
      .rst      (rst),
      .cpu_side (cpu_side),
      .hlda     (hlda),
      .path_en  (cpu_path_en)
   );

   AST_GRANT_POINT: assert property (@(posedge clk) disable iff (rst)
      $rose(hlda) |-> $past(tstate == TS_T4 || cpu_st == {ST_W{1'b1}})); // R3
   AST_GRANT_UNLOCKED: assert property (@(posedge clk) disable iff (rst)
      $rose(hlda) |-> $past(cpu_lock_n));                           // R5
   AST_GRANT_FREEZE: assert property (@(posedge clk) disable iff (rst)
      $rose(hlda) |-> (!rdy_en && wait_hold));                      // R4
   AST_NO_EARLY_REGRANT: assert property (@(posedge clk) disable iff (rst)
      $rose(hlda) |-> $past(!wait_hold));                           // R10

endmodule

// File: tb/test_hold_arb.sv
`timescale 1ns/1ps
module test_hold_arb;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       hreq = 1'b0;
   logic [2:0] cpu_st = 3'b111;
   logic       cpu_lock_n = 1'b1;
   logic [2:0] tstate = 3'd0;
   logic       hlda;
   logic [2:0] cpu_path_en;
   logic       rdy_en;
   logic       wait_hold;
   logic       cyc_restart;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   hold_arb i_hold_arb (
      .clk(clk), .rst(rst), .hreq(hreq), .cpu_st(cpu_st),
      .cpu_lock_n(cpu_lock_n), .tstate(tstate), .hlda(hlda),
      .cpu_path_en(cpu_path_en), .rdy_en(rdy_en),
      .wait_hold(wait_hold), .cyc_restart(cyc_restart)
   );

   // {hreq, cpu_st[2:0], lock_n, tstate[2:0], expected grant}
   localparam int NV = 12;
   localparam logic [8:0] VEC [NV] = '{
      {1'b1, 3'b111, 1'b1, 3'd0, 1'b1},   // passive idle
      {1'b1, 3'b111, 1'b1, 3'd2, 1'b1},   // passive wins over code
      {1'b1, 3'b100, 1'b1, 3'd4, 1'b1},   // T4
      {1'b1, 3'b010, 1'b1, 3'd4, 1'b1},   // T4 other status
      {1'b1, 3'b100, 1'b1, 3'd1, 1'b0},   // T1
      {1'b1, 3'b100, 1'b1, 3'd2, 1'b0},   // T2
      {1'b1, 3'b101, 1'b1, 3'd3, 1'b0},   // T3
      {1'b1, 3'b101, 1'b1, 3'd5, 1'b0},   // wait state
      {1'b1, 3'b111, 1'b0, 3'd0, 1'b0},   // locked passive
      {1'b1, 3'b100, 1'b0, 3'd4, 1'b0},   // locked T4
      {1'b0, 3'b111, 1'b1, 3'd4, 1'b0},   // no request
      {1'b1, 3'b000, 1'b1, 3'd4, 1'b1}    // T4 status zero
   };

   task automatic tick();
      @(negedge clk);
      #1;
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst = 1'b1; hreq = 1'b0; cpu_st = 3'b111; cpu_lock_n = 1'b1; tstate = 3'd0;
      tick(); tick();
      rst = 1'b0;
   endtask

   // bench-side monitor: grant point, overlap, drop timing
   logic in_hreq_q, in_safe_q, hlda_prev, drop_due;
   always @(posedge clk) begin
      in_hreq_q <= hreq;
      in_safe_q <= cpu_lock_n && (cpu_st == 3'b111 || tstate == 3'd4);
   end
   initial begin hlda_prev = 0; drop_due = 0; end
   always @(negedge clk) begin
      if (!rst) begin
         if (hlda && (cpu_path_en != 3'b000)) begin
            errors++;
            $display("FAIL R7 overlap actual=%0h expected=0", cpu_path_en);
         end
         if (hlda && !hlda_prev && !in_safe_q) begin
            errors++;
            $display("FAIL R3 grant at unsafe point actual=1 expected=0");
         end
         if (drop_due && hlda) begin
            errors++;
            $display("FAIL R6 late drop actual=1 expected=0");
         end
      end
      drop_due  = hlda && !hreq && !rst;
      hlda_prev = hlda;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      tick();
      // R1 reset state
      chk("R1 hlda", hlda, 0);
      chk("R1 paths", cpu_path_en, 3'b111);
      chk("R1 rdy", rdy_en, 1);
      chk("R1 wait", wait_hold, 0);
      chk("R1 restart", cyc_restart, 0);
      do_reset();

      // table walk: R2, R3, R5
      for (int v = 0; v < NV; v++) begin
         do_reset();
         {hreq, cpu_st, cpu_lock_n, tstate} = VEC[v][8:1];
         tick();
         chk("R2 R3 R5 table grant", hlda, VEC[v][0]);
      end

      // R4 grant bundle and R6 hold, then hand-back R7 R8 R9
      do_reset();
      hreq = 1; cpu_st = 3'b100; tstate = 3'd4;
      tick();
      chk("R4 hlda", hlda, 1);
      chk("R4 paths", cpu_path_en, 0);
      chk("R4 rdy", rdy_en, 0);
      chk("R4 wait", wait_hold, 1);
      cpu_lock_n = 0; tstate = 3'd2; cpu_st = 3'b001;
      tick(); tick();
      chk("R6 hold kept", hlda, 1);
      cpu_lock_n = 1; cpu_st = 3'b111; tstate = 3'd0;
      hreq = 0;
      tick();
      chk("R6 drop", hlda, 0);
      chk("R7 gap paths", cpu_path_en, 0);
      tick();
      chk("R7 reconnect", cpu_path_en, 3'b111);
      chk("R8 rdy still off", rdy_en, 0);
      chk("R8 wait still set", wait_hold, 1);
      tick();
      chk("R8 rdy back", rdy_en, 1);
      chk("R8 wait held", wait_hold, 1);
      chk("R9 no early restart", cyc_restart, 0);
      tick();
      chk("R8 wait clear", wait_hold, 0);
      chk("R9 restart", cyc_restart, 1);
      tick();
      chk("R9 restart single", cyc_restart, 0);

      // R10 request raised during hand-back
      do_reset();
      hreq = 1;
      tick();
      chk("R10 first grant", hlda, 1);
      hreq = 0;
      tick();
      hreq = 1;
      tick(); chk("R10 no grant in reconnect", hlda, 0);
      tick(); chk("R10 no grant in ready", hlda, 0);
      tick(); chk("R10 no grant at restart", hlda, 0);
      chk("R10 restart seen", cyc_restart, 1);
      tick(); chk("R10 regrant", hlda, 1);

      // R5 lock across two bus cycles that pass T4
      do_reset();
      hreq = 1; cpu_lock_n = 0; cpu_st = 3'b110;
      for (int c = 0; c < 2; c++) begin
         for (int t = 1; t <= 4; t++) begin
            tstate = 3'(t);
            tick();
            chk("R5 locked sequence", hlda, 0);
         end
      end
      cpu_lock_n = 1; tstate = 3'd4;
      tick();
      chk("R5 unlocked T4 grant", hlda, 1);

      // random CPU cycles and request timing; monitor checks R3 R6 R7
      do_reset();
      for (int n = 0; n < 600; n++) begin
         int kind, waits;
         kind = int'($urandom % 3);
         if ($urandom % 8 == 0) cpu_lock_n = ~cpu_lock_n;
         if (kind == 0) begin
            cpu_st = 3'b111;
            for (int k = 0; k <= int'($urandom % 3); k++) begin
               tstate = 3'd0;
               if (!hreq) hreq = ($urandom % 5 == 0);
               else if (hlda && $urandom % 4 == 0) hreq = 0;
               tick();
            end
         end else begin
            cpu_st = 3'($urandom % 7);
            waits = int'($urandom % 4);
            for (int k = 0; k < 4 + waits; k++) begin
               if (k < 3) tstate = 3'(k + 1);
               else if (k < 3 + waits) tstate = 3'd5;
               else tstate = 3'd4;
               if (!hreq) hreq = ($urandom % 5 == 0);
               else if (hlda && $urandom % 4 == 0) hreq = 0;
               tick();
            end
         end
      end
      hreq = 0;
      repeat (8) tick();
      chk("R7 random end paths", cpu_path_en, 3'b111);
      chk("R8 random end ready", rdy_en, 1);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule